// File: doc/BRIEF.md
# Dual Comparator Event and Interrupt Controller

This block is the digital wrapper for a pair of analog voltage comparators. Each comparator result arrives as an asynchronous bit. The block synchronises it and turns it into a clean output level. It records every change of that level in a sticky flag and combines the flags of both channels into one interrupt request. Software controls each channel through a small register port. The port sets the channel enable, the pin output enable and the interrupt enable, and it clears the channel's flag.

A channel that is switched off, or that sits in total power-down, shows a high output level. If that output was low, the forced rise counts as a change like any other. After a channel becomes active, its level is unreliable for a settling time. A per-channel counter therefore holds off change detection for `SETTLE_CYC` clock cycles and then reports the channel as settled. Total power-down acts on both channels at once. When it ends, each channel settles again. The register port is plain control and status, with no handshake. Writes take effect on the next clock edge, and reads are combinational.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset every channel is disabled, `cmp_out` is all ones, every flag, pin enable and interrupt enable is zero, and `irq` is low.
- R2: While a channel is disabled, its `cmp_out` bit is 1 whatever its raw input.
- R3: For an active, settled channel, a raw input change reaches `cmp_out` three clock edges later. The flag sets on that same edge, for both rising and falling changes.
- R4: Disabling a channel whose output is low drives the output high on the next edge and sets that channel's flag.
- R5: A flag stays set until a register write with bit 3 = 1 clears it. If a set event and a clear fall in the same cycle, the flag ends up set.
- R6: `irq` is high exactly when some channel has both its flag and its interrupt enable set.
- R7: For `SETTLE_CYC` edges after a channel becomes active, read bit 5 (settled) is 0 and output changes do not set the flag. After that window, bit 5 reads 1.
- R8: While `tpd_active` is high, both channels are forced inactive. Both outputs go high on the next edge, a low output sets its flag, and settling restarts when `tpd_active` falls.
- R9: `pin_oe[i]` follows the channel's pin enable. `pin_drive[i]` equals `cmp_out[i]` when the pin enable is set, and is 0 otherwise.
- R10: A write to channel `reg_addr` loads enable from bit 0, pin enable from bit 1 and interrupt enable from bit 2, and clears the flag if bit 3 is 1. A read returns {settled, out, flag, irq-enable, pin-enable, enable} in bits 5 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_raw | input | NUM_CH | Asynchronous comparator results |
| tpd_active | input | 1 | Total power-down in effect |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | CH_W | Channel selected for write and read |
| reg_wdata | input | 4 | Write data: clear, irq enable, pin enable, enable (bits 3..0) |
| reg_rdata | output | 6 | Read data of selected channel |
| cmp_out | output | NUM_CH | Synchronised, forced-high-when-off levels |
| pin_drive | output | NUM_CH | Level presented to the output pins |
| pin_oe | output | NUM_CH | Pin output enables |
| irq | output | 1 | Shared interrupt request |

## Verification
A corrupted settle counter shows up on read bit 5 and as a flag that appears, or fails to appear, when an output change lands in the masking window. A wrong bit-5 value is visible on the very cycle it goes wrong. A stuck or lost flag appears at `irq` and on read bit 3 in the cycle after the edge that should have set or cleared it. A broken disable or power-down path shows up as `cmp_out` staying low one edge after the channel stopped being active. The bench compares every port against its model on every cycle, so any such divergence is reported within a cycle of reaching the ports.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int WDATA_W = 4;
  localparam int RDATA_W = 6;
  localparam int WB_EN   = 0;
  localparam int WB_OE   = 1;
  localparam int WB_IE   = 2;
  localparam int WB_CLR  = 3;

  typedef struct packed {
    logic ie;
    logic oe;
    logic en;
  } chan_ctrl_t;

  localparam chan_ctrl_t CTRL_RESET = '{ie: 1'b0, oe: 1'b0, en: 1'b0};
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel #(
  parameter int SETTLE_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_async,
  input  logic en,
  input  logic tpd,
  input  logic clr,
  output logic out_q,
  output logic flag_q,
  output logic settled,
  output logic active
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(SETTLE_CYC);

  logic             raw_s;
  logic [CNT_W-1:0] cnt_q;
  logic             level_nxt;
  logic             change;

  cmp_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_async),
    .q     (raw_s)
  );

  assign active    = en & ~tpd;
  assign settled   = (cnt_q == CNT_LIM);
  assign level_nxt = active ? raw_s : 1'b1;
  // inactive channels always detect (forced rise); active ones only once settled
  assign change    = (level_nxt != out_q) && (!active || settled);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (!active)      cnt_q <= '0;
      else if (!settled) cnt_q <= cnt_q + 1'b1;
      out_q <= level_nxt;
      if (change)   flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int SETTLE_CYC = 2500,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  cmp_raw,
  input  logic               tpd_active,
  input  logic               reg_wr,
  input  logic [CH_W-1:0]    reg_addr,
  input  logic [WDATA_W-1:0] reg_wdata,
  output logic [RDATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0]  cmp_out,
  output logic [NUM_CH-1:0]  pin_drive,
  output logic [NUM_CH-1:0]  pin_oe,
  output logic               irq
);
  chan_ctrl_t        ctrl_q [NUM_CH];
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] ie_vec;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] active_vec;
  logic [NUM_CH-1:0] settled_vec;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel        = reg_wr && (reg_addr == CH_W'(i));
    assign clr_vec[i] = sel && reg_wdata[WB_CLR];
    assign ie_vec[i]  = ctrl_q[i].ie;
    assign pin_oe[i]  = ctrl_q[i].oe;
    assign pin_drive[i] = ctrl_q[i].oe & cmp_out[i];

    always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q[i] <= CTRL_RESET;
      else if (sel) begin
        ctrl_q[i].en <= reg_wdata[WB_EN];
        ctrl_q[i].oe <= reg_wdata[WB_OE];
        ctrl_q[i].ie <= reg_wdata[WB_IE];
      end
    end

    cmp_channel #(.SETTLE_CYC(SETTLE_CYC)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_async (cmp_raw[i]),
      .en        (ctrl_q[i].en),
      .tpd       (tpd_active),
      .clr       (clr_vec[i]),
      .out_q     (cmp_out[i]),
      .flag_q    (flag_q[i]),
      .settled   (settled_vec[i]),
      .active    (active_vec[i])
    );
  end

  assign irq = |(flag_q & ie_vec);

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == CH_W'(i))
        reg_rdata = {settled_vec[i], cmp_out[i], flag_q[i],
                     ctrl_q[i].ie, ctrl_q[i].oe, ctrl_q[i].en};
    end
  end
endmodule

// File: rtl/cmp_irq_ctrl_chk.sv
module cmp_irq_ctrl_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tpd_active,
  input logic [NUM_CH-1:0] cmp_out,
  input logic [NUM_CH-1:0] pin_drive,
  input logic              irq,
  input logic [NUM_CH-1:0] flag_q,
  input logic [NUM_CH-1:0] clr_vec,
  input logic [NUM_CH-1:0] active_vec,
  input logic [NUM_CH-1:0] settled_vec
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cmp_out == '1) && !irq);

  p_tpd_forces_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tpd_active |=> (cmp_out == '1));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & ~clr_vec)) |=> ((flag_q & $past(flag_q & ~clr_vec)) == $past(flag_q & ~clr_vec)));

  p_settle_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(active_vec & ~settled_vec)) |=>
      ((flag_q & ~$past(flag_q) & $past(active_vec & ~settled_vec)) == '0));

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !irq);

  p_pin_matches_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_drive & ~cmp_out) == '0);
endmodule

bind cmp_irq_ctrl cmp_irq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tpd_active  (tpd_active),
  .cmp_out     (cmp_out),
  .pin_drive   (pin_drive),
  .irq         (irq),
  .flag_q      (flag_q),
  .clr_vec     (clr_vec),
  .active_vec  (active_vec),
  .settled_vec (settled_vec)
);

// File: tb/cmp_irq_ctrl_tb.sv
`timescale 1ns/100ps
module cmp_irq_ctrl_tb_top;
  localparam int NCH = 2;
  localparam int S   = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmp_raw = 2'b11;
  logic       tpd_active = 1'b0;
  logic       reg_wr = 1'b0;
  logic [0:0] reg_addr = 1'b0;
  logic [3:0] reg_wdata = 4'd0;
  logic [5:0] reg_rdata;
  logic [1:0] cmp_out, pin_drive, pin_oe;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_irq_ctrl #(.NUM_CH(NCH), .SETTLE_CYC(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .tpd_active(tpd_active),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmp_out(cmp_out), .pin_drive(pin_drive),
    .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference model
  int m_s1[NCH], m_s2[NCH], m_out[NCH], m_flag[NCH], m_cnt[NCH];
  int m_en[NCH], m_oe[NCH], m_ie[NCH];

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      int act, lvl, det, clr, wsel;
      if (!rst_n) begin
        m_s1[c] = 1; m_s2[c] = 1; m_out[c] = 1; m_flag[c] = 0; m_cnt[c] = 0;
        m_en[c] = 0; m_oe[c] = 0; m_ie[c] = 0;
      end else begin
        act  = (m_en[c] != 0 && !tpd_active) ? 1 : 0;
        lvl  = act ? m_s2[c] : 1;
        det  = (lvl != m_out[c]) && (!act || m_cnt[c] == S);
        wsel = reg_wr && (int'(reg_addr) == c);
        clr  = wsel && reg_wdata[3];
        if (det) m_flag[c] = 1;
        else if (clr) m_flag[c] = 0;
        if (!act) m_cnt[c] = 0;
        else if (m_cnt[c] < S) m_cnt[c] = m_cnt[c] + 1;
        m_s2[c] = m_s1[c];
        m_s1[c] = int'(cmp_raw[c]);
        m_out[c] = lvl;
        if (wsel) begin
          m_en[c] = int'(reg_wdata[0]); m_oe[c] = int'(reg_wdata[1]); m_ie[c] = int'(reg_wdata[2]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int e_out, e_pin, e_oe, e_irq, e_rd, a;
      e_out = 0; e_pin = 0; e_oe = 0; e_irq = 0;
      for (int c = 0; c < NCH; c++) begin
        e_out |= m_out[c] << c;
        e_oe  |= m_oe[c] << c;
        e_pin |= (m_oe[c] & m_out[c]) << c;
        if (m_flag[c] && m_ie[c]) e_irq = 1;
      end
      a = int'(reg_addr);
      e_rd = ((m_cnt[a] == S) << 5) | (m_out[a] << 4) | (m_flag[a] << 3) |
             (m_ie[a] << 2) | (m_oe[a] << 1) | m_en[a];
      check(int'(cmp_out) == e_out, "R2 model cmp_out", int'(cmp_out), e_out);
      check(int'(pin_drive) == e_pin && int'(pin_oe) == e_oe, "R9 model pins",
            int'({pin_oe, pin_drive}), (e_oe << 2) | e_pin);
      check(int'(irq) == e_irq, "R6 model irq", int'(irq), e_irq);
      check(int'(reg_rdata) == e_rd, "R10 model rdata", int'(reg_rdata), e_rd);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input bit en, input bit oe, input bit ie, input bit clr);
    reg_addr  = 1'(ch);
    reg_wdata = {clr, ie, oe, en};
    reg_wr    = 1'b1;
    step();
    reg_wr    = 1'b0;
  endtask

  task automatic rdbit(input int ch, input int pos, input int exp, input string tag);
    reg_addr = 1'(ch);
    #0.1;
    check(int'(reg_rdata[pos]) == exp, tag, int'(reg_rdata[pos]), exp);
  endtask

  initial begin
    step(5);
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(cmp_out == 2'b11 && !irq, "R1 outputs after reset", int'({irq, cmp_out}), 3);
    reg_addr = 1'b0; #0.1;
    check(reg_rdata == 6'b010000, "R1 ch0 rdata after reset", int'(reg_rdata), 6'h10);

    // R2 disabled channel ignores raw
    cmp_raw = 2'b00;
    step(6);
    check(cmp_out == 2'b11, "R2 disabled forced high", int'(cmp_out), 3);
    rdbit(0, 3, 0, "R2 no flag while disabled");

    // R7 settle window masks detection
    wr(0, 1, 0, 1, 1);
    step(5);
    rdbit(0, 5, 0, "R7 not settled early");
    rdbit(0, 3, 0, "R7 flag masked during settle");
    step(S + 5);
    rdbit(0, 5, 1, "R7 settled after window");
    rdbit(0, 3, 0, "R7 still no flag");
    check(cmp_out[0] == 1'b0, "R3 level follows raw", int'(cmp_out[0]), 0);

    // R3 rising change, R6 irq
    cmp_raw[0] = 1'b1;
    step(2);
    check(cmp_out[0] == 1'b0, "R3 not yet propagated", int'(cmp_out[0]), 0);
    step();
    check(cmp_out[0] == 1'b1 && irq, "R3 rising edge flag/irq", int'({irq, cmp_out[0]}), 3);
    rdbit(0, 3, 1, "R3 rising flag");

    // R5 clear
    wr(0, 1, 0, 1, 1);
    rdbit(0, 3, 0, "R5 flag cleared");
    check(!irq, "R6 irq drops on clear", int'(irq), 0);

    // R3 falling change
    cmp_raw[0] = 1'b0;
    step(3);
    rdbit(0, 3, 1, "R3 falling flag");

    // R5 sticky / R6 masked by ie
    wr(0, 1, 0, 0, 0);
    rdbit(0, 3, 1, "R5 flag sticky");
    check(!irq, "R6 irq off with ie=0", int'(irq), 0);

    // R5 set wins over clear
    wr(0, 1, 0, 0, 1);
    cmp_raw[0] = 1'b1;
    step(2);
    reg_addr = 1'b0; reg_wdata = 4'b1001; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
    rdbit(0, 3, 1, "R5 set beats clear");

    // R9 pin drive
    wr(0, 1, 1, 0, 1);
    check(pin_oe[0] && pin_drive[0] == cmp_out[0], "R9 pin driven", int'(pin_drive[0]), int'(cmp_out[0]));
    wr(0, 1, 0, 0, 1);
    check(!pin_oe[0] && !pin_drive[0], "R9 pin off", int'({pin_oe[0], pin_drive[0]}), 0);

    // R4 disable with output low
    cmp_raw[0] = 1'b0;
    step(4);
    wr(0, 1, 0, 1, 1);
    check(cmp_out[0] == 1'b0 && !irq, "R4 precondition low", int'({irq, cmp_out[0]}), 0);
    wr(0, 0, 0, 1, 0);
    step();
    check(cmp_out[0] == 1'b1 && irq, "R4 disable raises flag", int'({irq, cmp_out[0]}), 3);
    rdbit(0, 3, 1, "R4 flag set by disable");

    // R8 total power-down
    wr(0, 1, 0, 0, 1);
    wr(1, 1, 0, 0, 1);
    step(S + 6);
    check(cmp_out == 2'b00, "R8 both low before power-down", int'(cmp_out), 0);
    tpd_active = 1'b1;
    step();
    check(cmp_out == 2'b11, "R8 forced high", int'(cmp_out), 3);
    rdbit(0, 3, 1, "R8 ch0 flag");
    rdbit(1, 3, 1, "R8 ch1 flag");
    rdbit(1, 5, 0, "R8 settle reset");
    step(5);
    tpd_active = 1'b0;
    step(5);
    rdbit(0, 5, 0, "R8 resettling");
    step(S + 2);
    rdbit(0, 5, 1, "R8 settled again");
    check(cmp_out == 2'b00, "R8 outputs follow raw again", int'(cmp_out), 0);
    // R10 field readback
    wr(1, 1, 1, 1, 1);
    reg_addr = 1'b1; #0.1;
    check(reg_rdata[2:0] == 3'b111, "R10 control field readback", int'(reg_rdata[2:0]), 7);
    step(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule